// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block holds a set of teletext page requests and decides, for each request, whether a page header received off air should be captured. A host programs a request through two ports. A configuration strobe loads a pointer that holds the request slot, the starting column, the bank and the slot-count mode. A data strobe then writes a series of 5-bit entries through one data port. After each write the column pointer moves to the next column by itself.

Each request has eight columns. Bit 4 of each column is a care flag and the low bits hold a digit. On the receive side, the magazine, the page tens and units digits and the four subcode digits of a header are presented together with a valid strobe. In the same cycle the block returns one match bit per slot of the selected bank. A column whose care flag is clear is left out of the comparison. This is how a request asks for every subcode version of a page.

Top module: `page_req_matcher`

## Requirements
- R1: After reset every stored entry, the slot and column pointer, the bank bit and the slot-count mode are zero. Because no care flag is set, a valid header then matches slots 0 to 8 (matchVec = 10'h1FF).
- R2: A cfgWe pulse loads slot, column, bank and mode. Each accepted dataWe stores dataIn at the current column of the current slot. The column then advances by one and wraps from 7 to 0. The slot does not change.
- R3: While the held slot index is 10 or more, dataWe stores nothing. Every match result stays as it was.
- R4: Entry layout, with bit 4 as the care flag. Column 0 bits 2:0 hold the magazine (bit 3 is a hold flag and is not compared). Column 1 bits 3:0 hold the page tens and column 2 bits 3:0 the page units. Column 3 bits 1:0 hold the hour tens and column 4 bits 3:0 the hour units. Column 5 bits 2:0 hold the minute tens and column 6 bits 3:0 the minute units. Column 7 holds a flag field that is not compared.
- R5: A slot matches when every compared column whose care flag is 1 equals the matching header digit. Columns whose care flag is 0 are ignored.
- R6: With the mode bit at 1, all 10 slots can match. With it at 0, slot 9 never matches.
- R7: The bank bit selects one of two banks of 10 slots. Writes go to the held bank and matchVec reports the slots of the held bank.
- R8: matchVec is zero whenever hdrValid is low. It depends combinationally on the header in the same cycle.
- R9: When cfgWe and dataWe occur in the same cycle, the data goes to the pointer held before that edge. After the edge the pointer holds the newly configured values, with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the pointer and mode fields |
| cfgSlot | input | 4 | Request slot index |
| cfgCol | input | 3 | Starting column |
| cfgBank | input | 1 | Bank select |
| cfgAllSlots | input | 1 | 1: all 10 slots active; 0: slot 9 inactive |
| dataWe | input | 1 | Write dataIn at the pointer |
| dataIn | input | 5 | Entry: care flag in bit 4, digit in bits 3:0 |
| hdrValid | input | 1 | Header fields are valid this cycle |
| hdrMag | input | 3 | Received magazine |
| hdrTens | input | 4 | Received page tens |
| hdrUnits | input | 4 | Received page units |
| hdrHourTens | input | 2 | Received hour tens |
| hdrHourUnits | input | 4 | Received hour units |
| hdrMinTens | input | 3 | Received minute tens |
| hdrMinUnits | input | 4 | Received minute units |
| matchVec | output | 10 | Per-slot match for the held bank |

## Verification
A pointer reconfiguration and a data write can land on the same clock edge. The bench provokes this by raising cfgWe and dataWe together, with a new slot and column that differ from the held ones. It then writes one more entry and probes both slots against headers built from a bench-side model. The collision is judged correct only if the first entry went to the old slot and the second entry went to the newly loaded column with no extra increment.

// File: rtl/page_req_pkg.sv
package page_req_pkg;
  localparam int SLOT_W = 4;
  localparam int COL_W  = 3;
  localparam int ENT_W  = 5;
  localparam int NCOLS  = 1 << COL_W;
  localparam int NCMP   = 7;

  typedef struct packed {
    logic               wrEn;
    logic               bank;
    logic [SLOT_W-1:0]  slot;
    logic [COL_W-1:0]   col;
  } wrStrobe_t;

  typedef struct packed {
    logic [2:0] mag;
    logic [3:0] tens;
    logic [3:0] units;
    logic [1:0] hourTens;
    logic [3:0] hourUnits;
    logic [2:0] minTens;
    logic [3:0] minUnits;
  } header_t;

  function automatic logic [3:0] fieldMask(input logic [COL_W-1:0] col);
    case (col)
      3'd0, 3'd5: fieldMask = 4'h7;
      3'd3:       fieldMask = 4'h3;
      3'd7:       fieldMask = 4'h0;
      default:    fieldMask = 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] hdrDigit(input header_t h, input logic [COL_W-1:0] col);
    case (col)
      3'd0:    hdrDigit = {1'b0, h.mag};
      3'd1:    hdrDigit = h.tens;
      3'd2:    hdrDigit = h.units;
      3'd3:    hdrDigit = {2'b0, h.hourTens};
      3'd4:    hdrDigit = h.hourUnits;
      3'd5:    hdrDigit = {1'b0, h.minTens};
      3'd6:    hdrDigit = h.minUnits;
      default: hdrDigit = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/page_req_ctrl.sv
module page_req_ctrl
  import page_req_pkg::*;
#(
  parameter int NUM_SLOTS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [COL_W-1:0]  cfgCol,
  input  logic              cfgBank,
  input  logic              cfgAllSlots,
  input  logic              dataWe,
  output wrStrobe_t         strobe,
  output logic              bankQ,
  output logic              allSlotsQ
);
  logic [SLOT_W-1:0] slotQ;
  logic [COL_W-1:0]  colQ;
  logic              accept;

  assign accept = dataWe && (int'(slotQ) < NUM_SLOTS);

  always_comb begin
    strobe.wrEn = accept;
    strobe.bank = bankQ;
    strobe.slot = slotQ;
    strobe.col  = colQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ     <= '0;
      colQ      <= '0;
      bankQ     <= 1'b0;
      allSlotsQ <= 1'b0;
    end else if (cfgWe) begin
      slotQ     <= cfgSlot;
      colQ      <= cfgCol;
      bankQ     <= cfgBank;
      allSlotsQ <= cfgAllSlots;
    end else if (accept) begin
      colQ <= colQ + 1'b1;
    end
  end

  // R2
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && !cfgWe && strobe.wrEn && colQ == '1) |=> (colQ == '0));
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe) |=> $stable(slotQ) && $stable(bankQ));
  // R3
  reject_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(slotQ) >= NUM_SLOTS) |-> !strobe.wrEn);
  // R9
  cfg_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (colQ == $past(cfgCol)) && (slotQ == $past(cfgSlot)));
endmodule

// File: rtl/page_req_store.sv
module page_req_store
  import page_req_pkg::*;
#(
  parameter int NUM_SLOTS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strobe,
  input  logic [ENT_W-1:0]     dataIn,
  input  logic                 bankSel,
  input  logic                 allSlots,
  input  logic                 hdrValid,
  input  header_t              hdr,
  output logic [NUM_SLOTS-1:0] matchVec
);
  localparam int SW = $clog2(NUM_SLOTS);

  logic [ENT_W-1:0] mem [2][NUM_SLOTS][NCOLS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NUM_SLOTS; s++)
          for (int c = 0; c < NCOLS; c++)
            mem[b][s][c] <= '0;
    end else if (strobe.wrEn) begin
      mem[strobe.bank][strobe.slot[SW-1:0]][strobe.col] <= dataIn;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    logic active;
    always_comb begin
      hit = 1'b1;
      for (int c = 0; c < NCMP; c++) begin
        if (mem[bankSel][s][c][4] &&
            (((mem[bankSel][s][c][3:0] ^ hdrDigit(hdr, 3'(c))) & fieldMask(3'(c))) != 4'h0))
          hit = 1'b0;
      end
    end
    assign active      = (s < NUM_SLOTS - 1) || allSlots;
    assign matchVec[s] = hdrValid && active && hit;
  end

  // R8
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec != '0) |-> hdrValid);
  // R6
  top_slot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allSlots |-> !matchVec[NUM_SLOTS-1]);
endmodule

// File: rtl/page_req_matcher.sv
module page_req_matcher
  import page_req_pkg::*;
#(
  parameter int NUM_SLOTS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [3:0]           cfgSlot,
  input  logic [2:0]           cfgCol,
  input  logic                 cfgBank,
  input  logic                 cfgAllSlots,
  input  logic                 dataWe,
  input  logic [4:0]           dataIn,
  input  logic                 hdrValid,
  input  logic [2:0]           hdrMag,
  input  logic [3:0]           hdrTens,
  input  logic [3:0]           hdrUnits,
  input  logic [1:0]           hdrHourTens,
  input  logic [3:0]           hdrHourUnits,
  input  logic [2:0]           hdrMinTens,
  input  logic [3:0]           hdrMinUnits,
  output logic [NUM_SLOTS-1:0] matchVec
);
  wrStrobe_t strobe;
  logic      bankQ;
  logic      allSlotsQ;
  header_t   hdr;

  assign hdr = '{mag: hdrMag, tens: hdrTens, units: hdrUnits,
                 hourTens: hdrHourTens, hourUnits: hdrHourUnits,
                 minTens: hdrMinTens, minUnits: hdrMinUnits};

  page_req_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgCol(cfgCol),
    .cfgBank(cfgBank), .cfgAllSlots(cfgAllSlots), .dataWe(dataWe),
    .strobe(strobe), .bankQ(bankQ), .allSlotsQ(allSlotsQ)
  );

  page_req_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .bankSel(bankQ),
    .allSlots(allSlotsQ), .hdrValid(hdrValid), .hdr(hdr), .matchVec(matchVec)
  );
endmodule

// File: tb/page_req_matcher_test.sv
`timescale 1ns/1ps
module page_req_matcher_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0, cfgBank = 1'b0, cfgAllSlots = 1'b0, dataWe = 1'b0, hdrValid = 1'b0;
  logic [3:0] cfgSlot = '0;
  logic [2:0] cfgCol = '0;
  logic [4:0] dataIn = '0;
  logic [2:0] hdrMag = '0, hdrMinTens = '0;
  logic [3:0] hdrTens = '0, hdrUnits = '0, hdrHourUnits = '0, hdrMinUnits = '0;
  logic [1:0] hdrHourTens = '0;
  logic [9:0] matchVec;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [4:0] mdl [2][10][8];
  int curSlot = 0, curCol = 0, curBank = 0, curAll = 0;
  int hf [7];
  int mk [7] = '{7, 15, 15, 3, 15, 7, 15};

  always #2.5 clk = ~clk;

  page_req_matcher uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgCol(cfgCol),
    .cfgBank(cfgBank), .cfgAllSlots(cfgAllSlots), .dataWe(dataWe), .dataIn(dataIn),
    .hdrValid(hdrValid), .hdrMag(hdrMag), .hdrTens(hdrTens), .hdrUnits(hdrUnits),
    .hdrHourTens(hdrHourTens), .hdrHourUnits(hdrHourUnits), .hdrMinTens(hdrMinTens),
    .hdrMinUnits(hdrMinUnits), .matchVec(matchVec)
  );

  function automatic logic [9:0] expVec(input bit v);
    logic [9:0] r = '0;
    for (int s = 0; s < 10; s++) begin
      bit ok = v && (s < 9 || curAll != 0);
      for (int c = 0; c < 7; c++) begin
        logic [4:0] e = mdl[curBank][s][c];
        if (e[4] && ((int'(e[3:0]) & mk[c]) != (hf[c] & mk[c]))) ok = 0;
      end
      r[s] = ok;
    end
    return r;
  endfunction

  task automatic chk(input bit v, input string tag);
    logic [9:0] e;
    @(negedge clk);
    hdrValid = v;
    hdrMag = 3'(hf[0]); hdrTens = 4'(hf[1]); hdrUnits = 4'(hf[2]);
    hdrHourTens = 2'(hf[3]); hdrHourUnits = 4'(hf[4]);
    hdrMinTens = 3'(hf[5]); hdrMinUnits = 4'(hf[6]);
    #1;
    e = expVec(v);
    checks++;
    if (matchVec !== e) begin
      errors++;
      $display("FAIL %s: matchVec=%h expected=%h", tag, matchVec, e);
    end
  endtask

  task automatic cfg(input int s, input int c, input int b, input int a);
    @(negedge clk);
    cfgWe = 1; cfgSlot = 4'(s); cfgCol = 3'(c); cfgBank = 1'(b); cfgAllSlots = 1'(a);
    @(negedge clk);
    cfgWe = 0;
    curSlot = s; curCol = c; curBank = b; curAll = a;
  endtask

  task automatic modelWrite(input logic [4:0] v);
    if (curSlot < 10) begin
      mdl[curBank][curSlot][curCol] = v;
      curCol = (curCol + 1) % 8;
    end
  endtask

  task automatic wr(input logic [4:0] v);
    @(negedge clk);
    dataWe = 1; dataIn = v;
    @(negedge clk);
    dataWe = 0;
    modelWrite(v);
  endtask

  task automatic probeSlot(input int s, input string tag);
    for (int c = 0; c < 7; c++) hf[c] = int'(mdl[curBank][s][c][3:0]) & mk[c];
    chk(1, tag);
    for (int c = 0; c < 7; c++) begin
      int keep = hf[c];
      hf[c] = (keep ^ 1) & mk[c];
      chk(1, tag);
      hf[c] = keep;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 10; s++)
        for (int c = 0; c < 8; c++) mdl[b][s][c] = '0;
    for (int c = 0; c < 7; c++) hf[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R8 / R1: reset state, with no header and with one
    chk(0, "R8 no valid after reset");
    chk(1, "R1 reset contents wildcard");
    // R4 / R5: one request, subcodes left as don't care
    cfg(3, 0, 0, 0);
    wr(5'h1D); wr(5'h12); wr(5'h17); wr(5'h03); wr(5'h05); wr(5'h02); wr(5'h09); wr(5'h1F);
    probeSlot(3, "R4 layout slot3");
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < 10; t++) begin
        hf[0] = m; hf[1] = t; hf[2] = 7; hf[3] = t % 4; hf[4] = m; hf[5] = t % 8; hf[6] = m + t;
        chk(1, "R5 care sweep");
      end
    // R4 / R6: fill all slots with arithmetic patterns, all ten active
    for (int s = 0; s < 10; s++) begin
      cfg(s, 0, 0, 1);
      for (int c = 0; c < 8; c++) wr(5'((s * 7 + c * 3 + (s >> 1)) % 32));
    end
    for (int s = 0; s < 10; s++) probeSlot(s, "R5 per-slot probe");
    cfg(9, 0, 0, 0);
    probeSlot(9, "R6 slot 9 inactive");
    cfg(9, 0, 0, 1);
    probeSlot(9, "R6 slot 9 active");
    // R2: column wrap from 7 to 0
    cfg(5, 6, 0, 1);
    for (int k = 0; k < 10; k++) wr(5'(16 + (k * 5) % 16));
    probeSlot(5, "R2 wrap");
    // R3: out-of-range slots take no writes
    cfg(11, 0, 0, 1);
    for (int k = 0; k < 8; k++) wr(5'h1A);
    cfg(15, 3, 0, 1);
    for (int k = 0; k < 4; k++) wr(5'h10);
    for (int s = 0; s < 10; s++) probeSlot(s, "R3 rejected writes");
    // R7: bank 1 independent from bank 0
    cfg(2, 0, 1, 1);
    for (int c = 0; c < 8; c++) wr(5'(16 + c));
    probeSlot(2, "R7 bank1 slot2");
    probeSlot(0, "R7 bank1 slot0 reset");
    cfg(0, 0, 0, 1);
    probeSlot(2, "R7 bank0 slot2 kept");
    // R9: configuration and data on the same edge
    cfg(4, 1, 0, 1);
    @(negedge clk);
    cfgWe = 1; cfgSlot = 4'd6; cfgCol = 3'd3; cfgBank = 0; cfgAllSlots = 1;
    dataWe = 1; dataIn = 5'h1B;
    @(negedge clk);
    cfgWe = 0; dataWe = 0;
    modelWrite(5'h1B);
    curSlot = 6; curCol = 3; curBank = 0; curAll = 1;
    wr(5'h15);
    probeSlot(4, "R9 old pointer slot4");
    probeSlot(6, "R9 new pointer slot6");
    // R8: a matching header without valid
    for (int c = 0; c < 7; c++) hf[c] = int'(mdl[0][6][c][3:0]) & mk[c];
    chk(0, "R8 matching header without valid");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule